// File: doc/BRIEF.md
# In-Order Store Writeback Queue

This block holds stores from the moment they are dispatched until the data cache has finished with them. Stores enter at the tail in program order, each with an address, data, a byte size, a sequence number and two flags for store-conditional handling. A commit input names the youngest retired sequence number. The queue marks every store up to that point as ready to leave and counts how many of them are still waiting to finish.

A writeback pointer sits between the oldest entry and the tail. Each cycle it offers at most one ready store to the cache over a valid/ready request. A refused request puts the queue into a blocked state. The request is then offered again only when the cache pulses its retry input. Completion responses return the queue slot and may arrive in any order. The oldest entry retires only when it is done, and it retires together with the whole run of done entries behind it.

A squash input removes the youngest stores that have not yet been marked for writeback. Stores with no bytes, and store-conditionals that lose their lock on a cacheable address, finish inside the queue without any cache traffic.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: used_count is 0, pending_count is 0, req_valid is 0 and alloc_ready is 1.
- R2: A store is written at the tail when alloc_valid and alloc_ready are high and squash_valid is low, and used_count rises by one on the next cycle. alloc_ready is low while CAPACITY stores are held, and an allocation attempted then has no effect.
- R3: commit_valid scans from the oldest store toward the youngest. It marks each unmarked store whose sequence number is not greater than commit_seq, skips stores that are already marked, and stops at the first unmarked store with a greater sequence number. pending_count rises by the number of stores it marks.
- R4: Marked stores are offered strictly oldest first, one per cycle. req_addr, req_data and req_size carry the store's fields and req_idx carries its slot; slots are used in order 0,1,..,CAPACITY and then wrap to 0. A request is never offered with size 0.
- R5: A request seen with req_valid high and req_ready low blocks the queue. req_valid then stays low until a cycle with retry high. In that cycle the same slot is offered again, and acceptance clears the block.
- R6: A marked store of size 0 completes without a request. pending_count falls by one, and the store retires once it is the oldest entry.
- R7: For a store-conditional (locked) store, req_sc is 2 when it is uncacheable and 1 when it is cacheable and lock_flag is high. When it is cacheable and lock_flag is low, it completes with no request. Ordinary stores carry req_sc 0.
- R8: resp_valid marks slot resp_idx done and lowers pending_count by one. The oldest store retires only when done, taking every contiguous done store after it in the same cycle, so used_count falls by the length of that run.
- R9: squash_valid removes stores from the youngest backward while their sequence number exceeds squash_seq. It stops at the first store that is already marked. Allocation and commit are ignored in a squash cycle.
- R10: pending_count never exceeds used_count, and used_count never exceeds CAPACITY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New store present |
| alloc_addr | input | AW | Store address |
| alloc_data | input | DW | Store data |
| alloc_size | input | SZW | Store size in bytes |
| alloc_seq | input | SQW | Store sequence number |
| alloc_locked | input | 1 | Store-conditional |
| alloc_uncached | input | 1 | Uncacheable access |
| alloc_ready | output | 1 | Space available |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | SQW | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SQW | Stores younger than this are removed |
| lock_flag | input | 1 | Reservation still held |
| req_valid | output | 1 | Cache write request |
| req_ready | input | 1 | Cache accepts request |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| req_size | output | SZW | Request size |
| req_idx | output | IW | Queue slot of request |
| req_sc | output | 2 | Store-conditional result code |
| retry | input | 1 | Cache invites a resend |
| resp_valid | input | 1 | Completion response |
| resp_idx | input | IW | Slot that completed |
| used_count | output | IW+1 | Stores held |
| pending_count | output | IW+1 | Marked stores not yet done |

## Verification
The hardest state to reach from the ports is a run of done entries waiting behind an oldest entry that is not done. The stimulus marks three stores and lets all three issue. It then answers the youngest two first and the oldest last, so a single response retires three entries. A second hard case is a squash that must stop at a marked entry. The bench reaches it with a squash cycle that also carries a commit, which the queue must ignore. The refused-request path is driven by holding req_ready low and then pulsing retry once with the cache still refusing and once with it accepting.

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
  parameter int CAPACITY = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SZW = 4,
  parameter int SQW = 16,
  localparam int DEPTH = CAPACITY + 1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  input  logic [AW-1:0]  alloc_addr,
  input  logic [DW-1:0]  alloc_data,
  input  logic [SZW-1:0] alloc_size,
  input  logic [SQW-1:0] alloc_seq,
  input  logic           alloc_locked,
  input  logic           alloc_uncached,
  output logic           alloc_ready,
  input  logic           commit_valid,
  input  logic [SQW-1:0] commit_seq,
  input  logic           squash_valid,
  input  logic [SQW-1:0] squash_seq,
  input  logic           lock_flag,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  output logic [DW-1:0]  req_data,
  output logic [SZW-1:0] req_size,
  output logic [IW-1:0]  req_idx,
  output logic [1:0]     req_sc,
  input  logic           retry,
  input  logic           resp_valid,
  input  logic [IW-1:0]  resp_idx,
  output logic [IW:0]    used_count,
  output logic [IW:0]    pending_count
);

  logic [AW-1:0]  st_addr [DEPTH];
  logic [DW-1:0]  st_data [DEPTH];
  logic [SZW-1:0] st_size [DEPTH];
  logic [SQW-1:0] st_seq  [DEPTH];
  logic [DEPTH-1:0] st_lock, st_unc, elig, done;

  logic [IW-1:0] head, wbp, tail;
  logic [IW:0]   pending;
  logic          blocked;
  int            used_i;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] p, input int n);
    int t;
    t = (int'(p) + n) % DEPTH;
    return t[IW-1:0];
  endfunction

  always_comb begin
    used_i = int'(tail) - int'(head);
    if (used_i < 0) used_i += DEPTH;
  end

  assign used_count    = used_i[IW:0];
  assign pending_count = pending;
  assign alloc_ready   = used_i < CAPACITY;

  logic alloc_fire, commit_go;
  assign alloc_fire = alloc_valid && alloc_ready && !squash_valid;
  assign commit_go  = commit_valid && !squash_valid;

  logic wb_ent, wb_local, wb_adv;
  assign wb_ent   = (pending != '0) && (wbp != tail) && elig[wbp];
  assign wb_local = wb_ent && !blocked &&
                    ((st_size[wbp] == '0) || (st_lock[wbp] && !st_unc[wbp] && !lock_flag));
  assign req_valid = wb_ent && !wb_local && (!blocked || retry);
  assign wb_adv    = wb_local || (req_valid && req_ready);
  assign req_addr  = st_addr[wbp];
  assign req_data  = st_data[wbp];
  assign req_size  = st_size[wbp];
  assign req_idx   = wbp;
  assign req_sc    = !st_lock[wbp] ? 2'd0 : (st_unc[wbp] ? 2'd2 : 2'd1);

  logic [DEPTH-1:0] cmark;
  logic [IW:0]      ncommit;
  always_comb begin
    logic stop;
    logic [IW-1:0] i;
    cmark = '0;
    ncommit = '0;
    stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      i = wrap_add(head, k);
      if (commit_go && k < used_i && !stop && !elig[i]) begin
        if (st_seq[i] > commit_seq) stop = 1'b1;
        else begin
          cmark[i] = 1'b1;
          ncommit = ncommit + 1'b1;
        end
      end
    end
  end

  logic [IW-1:0] new_tail;
  always_comb begin
    logic stop;
    logic [IW-1:0] i;
    new_tail = tail;
    stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      i = wrap_add(tail, DEPTH - 1 - k);
      if (k < used_i && !stop) begin
        if (elig[i] || st_seq[i] <= squash_seq) stop = 1'b1;
        else new_tail = i;
      end
    end
  end

  logic [DEPTH-1:0] done_nx;
  logic [IW:0]      adv, ncomp;
  always_comb begin
    logic stop;
    logic [IW-1:0] i;
    done_nx = done;
    if (resp_valid) done_nx[resp_idx] = 1'b1;
    if (wb_local)   done_nx[wbp] = 1'b1;
    ncomp = {{IW{1'b0}}, resp_valid} + {{IW{1'b0}}, wb_local};
    adv = '0;
    stop = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      i = wrap_add(head, k);
      if (k < used_i && !stop) begin
        if (done_nx[i]) adv = adv + 1'b1;
        else stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      wbp     <= '0;
      tail    <= '0;
      pending <= '0;
      blocked <= 1'b0;
      elig    <= '0;
      done    <= '0;
      st_lock <= '0;
      st_unc  <= '0;
    end else begin
      elig    <= elig | cmark;
      done    <= done_nx;
      head    <= wrap_add(head, int'(adv));
      pending <= pending + ncommit - ncomp;
      if (wb_adv) wbp <= wrap_add(wbp, 1);
      if (req_valid && !req_ready) blocked <= 1'b1;
      else if (req_valid && req_ready) blocked <= 1'b0;
      if (squash_valid) tail <= new_tail;
      else if (alloc_fire) begin
        st_addr[tail] <= alloc_addr;
        st_data[tail] <= alloc_data;
        st_size[tail] <= alloc_size;
        st_seq[tail]  <= alloc_seq;
        st_lock[tail] <= alloc_locked;
        st_unc[tail]  <= alloc_uncached;
        elig[tail]    <= 1'b0;
        done[tail]    <= 1'b0;
        tail          <= wrap_add(tail, 1);
      end
    end
  end

  // R10
  bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_count <= used_count) && (used_count <= CAPACITY));

  // R5
  hold_until_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!req_valid || retry));

  // R5
  resend_same_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(req_idx));

  // R9
  squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (used_count <= $past(used_count)));

  // R4
  no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0));

endmodule

// File: tb/store_commit_queue_test.sv
module store_commit_queue_test;
  localparam int CLK = 10;
  localparam int CAP = 4;
  localparam int DEPTH = CAP + 1;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_locked = 0, alloc_uncached = 0;
  logic [31:0] alloc_addr = 0, alloc_data = 0;
  logic [3:0] alloc_size = 0;
  logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic commit_valid = 0, squash_valid = 0, lock_flag = 0;
  logic req_ready = 1, retry = 0, resp_valid = 0;
  logic [IW-1:0] resp_idx = 0;
  logic alloc_ready, req_valid;
  logic [31:0] req_addr, req_data;
  logic [3:0] req_size;
  logic [IW-1:0] req_idx;
  logic [1:0] req_sc;
  logic [IW:0] used_count, pending_count;

  store_commit_queue #(.CAPACITY(CAP)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_size(alloc_size), .alloc_seq(alloc_seq), .alloc_locked(alloc_locked),
    .alloc_uncached(alloc_uncached), .alloc_ready(alloc_ready),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .lock_flag(lock_flag),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_size(req_size), .req_idx(req_idx), .req_sc(req_sc),
    .retry(retry), .resp_valid(resp_valid), .resp_idx(resp_idx),
    .used_count(used_count), .pending_count(pending_count));

  always #(CLK/2) clk = ~clk;

  int total = 0, bad = 0, nlog = 0;
  int log_addr [64];
  int log_data [64];
  int log_size [64];
  int log_idx  [64];
  int log_sc   [64];

  always @(negedge clk)
    if (rst_n && req_valid && req_ready && nlog < 64) begin
      log_addr[nlog] = int'(req_addr);
      log_data[nlog] = int'(req_data);
      log_size[nlog] = int'(req_size);
      log_idx[nlog]  = int'(req_idx);
      log_sc[nlog]   = int'(req_sc);
      nlog++;
    end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input int addr, input int data, input int size, input int seq,
                      input bit lk, input bit unc);
    alloc_valid = 1; alloc_addr = addr; alloc_data = data; alloc_size = size[3:0];
    alloc_seq = seq[15:0]; alloc_locked = lk; alloc_uncached = unc;
    tick();
    alloc_valid = 0; alloc_locked = 0; alloc_uncached = 0;
  endtask

  task automatic commit(input int seq);
    commit_valid = 1; commit_seq = seq[15:0];
    tick();
    commit_valid = 0;
  endtask

  task automatic resp(input int idx);
    resp_valid = 1; resp_idx = idx[IW-1:0];
    tick();
    resp_valid = 0;
  endtask

  localparam logic [67:0] VEC [8] = '{
    {32'h0000_1000, 32'hA5A5_0001, 4'd4},
    {32'h0000_1010, 32'h1234_5678, 4'd0},
    {32'h0000_2000, 32'hDEAD_BEEF, 4'd8},
    {32'h0000_2008, 32'h0000_00FF, 4'd1},
    {32'h0000_3000, 32'h5555_AAAA, 4'd0},
    {32'h0000_3004, 32'h0BAD_F00D, 4'd2},
    {32'h0000_4000, 32'h7777_1111, 4'd4},
    {32'h0000_4100, 32'hCAFE_0042, 4'd8}};

  initial begin
    #(CLK * 50000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int slot, base, sidx;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(used_count == 0, "R1 used", used_count, 0);
    chk(pending_count == 0, "R1 pending", pending_count, 0);
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);

    slot = 0;
    for (int r = 0; r < 8; r++) begin
      base = nlog;
      push(int'(VEC[r][67:36]), int'(VEC[r][35:4]), int'(VEC[r][3:0]), r + 1, 0, 0);
      commit(r + 1);
      tick(); tick();
      @(negedge clk);
      if (VEC[r][3:0] != 0) begin
        chk(nlog == base + 1, "R4 one request", nlog - base, 1);
        chk(log_addr[base] == int'(VEC[r][67:36]), "R4 addr", log_addr[base], int'(VEC[r][67:36]));
        chk(log_data[base] == int'(VEC[r][35:4]), "R4 data", log_data[base], int'(VEC[r][35:4]));
        chk(log_size[base] == int'(VEC[r][3:0]), "R4 size", log_size[base], int'(VEC[r][3:0]));
        chk(log_idx[base] == slot, "R4 slot", log_idx[base], slot);
        chk(log_sc[base] == 0, "R7 plain sc", log_sc[base], 0);
        resp(log_idx[base]);
      end else begin
        chk(nlog == base, "R6 no request", nlog - base, 0);
      end
      @(negedge clk);
      chk(used_count == 0, "R8 retired", used_count, 0);
      chk(pending_count == 0, "R6 pending", pending_count, 0);
      slot = (slot + 1) % DEPTH;
    end

    // R3 partial commit, then skip of already-marked stores
    base = nlog;
    push(32'h100, 10, 4, 10, 0, 0);
    push(32'h110, 11, 4, 11, 0, 0);
    push(32'h120, 12, 4, 12, 0, 0);
    commit(11);
    @(negedge clk);
    chk(pending_count == 2, "R3 marked two", pending_count, 2);
    tick(); tick(); tick();
    @(negedge clk);
    chk(nlog == base + 2, "R3 stop at younger", nlog - base, 2);
    chk(req_valid == 0, "R3 unmarked not offered", req_valid, 0);
    commit(12);
    @(negedge clk);
    chk(pending_count == 3, "R3 skip marked", pending_count, 3);
    tick(); tick();
    @(negedge clk);
    chk(nlog == base + 3, "R4 third issued", nlog - base, 3);
    chk(log_addr[base] == 32'h100 && log_addr[base+1] == 32'h110 && log_addr[base+2] == 32'h120,
        "R4 order", log_addr[base+1], 32'h110);
    // R8 out-of-order completion
    resp(log_idx[base+1]);
    @(negedge clk);
    chk(used_count == 3, "R8 head not done", used_count, 3);
    resp(log_idx[base+2]);
    @(negedge clk);
    chk(used_count == 3, "R8 still waiting", used_count, 3);
    chk(pending_count == 1, "R8 pending", pending_count, 1);
    resp(log_idx[base]);
    @(negedge clk);
    chk(used_count == 0, "R8 run retires", used_count, 0);

    // R9 squash
    base = nlog;
    push(32'h200, 20, 4, 20, 0, 0);
    push(32'h210, 21, 4, 21, 0, 0);
    push(32'h220, 22, 4, 22, 0, 0);
    push(32'h230, 23, 4, 23, 0, 0);
    commit(20);
    squash_valid = 1; squash_seq = 21;
    commit_valid = 1; commit_seq = 30;
    alloc_valid = 1; alloc_addr = 32'h990; alloc_size = 4; alloc_seq = 99;
    tick();
    squash_valid = 0; commit_valid = 0; alloc_valid = 0;
    @(negedge clk);
    chk(used_count == 2, "R9 squash two", used_count, 2);
    chk(pending_count == 1, "R9 commit ignored", pending_count, 1);
    squash_valid = 1; squash_seq = 19;
    tick();
    squash_valid = 0;
    @(negedge clk);
    chk(used_count == 1, "R9 stop at marked", used_count, 1);
    chk(nlog == base + 1, "R9 marked store sent", nlog - base, 1);
    resp(log_idx[base]);
    @(negedge clk);
    chk(used_count == 0 && pending_count == 0, "R9 drained", used_count, 0);

    // R5 refusal and retry
    req_ready = 0;
    base = nlog;
    push(32'h400, 40, 4, 40, 0, 0);
    commit(40);
    @(negedge clk);
    chk(req_valid == 1, "R5 first offer", req_valid, 1);
    sidx = int'(req_idx);
    tick(); tick(); tick();
    @(negedge clk);
    chk(req_valid == 0, "R5 held while blocked", req_valid, 0);
    retry = 1;
    @(negedge clk);
    chk(req_valid == 1 && int'(req_idx) == sidx, "R5 resend same slot", req_idx, sidx);
    tick();
    retry = 0;
    @(negedge clk);
    chk(req_valid == 0, "R5 still blocked", req_valid, 0);
    retry = 1; req_ready = 1;
    tick();
    retry = 0;
    @(negedge clk);
    chk(nlog == base + 1 && req_valid == 0, "R5 accepted once", nlog - base, 1);
    resp(log_idx[base]);
    @(negedge clk);
    chk(used_count == 0, "R5 drained", used_count, 0);

    // R7 store-conditional
    lock_flag = 1;
    base = nlog;
    push(32'h500, 50, 4, 50, 1, 0);
    commit(50);
    tick(); tick();
    @(negedge clk);
    chk(nlog == base + 1 && log_sc[base] == 1, "R7 locked held", log_sc[base], 1);
    resp(log_idx[base]);
    push(32'h510, 51, 4, 51, 1, 1);
    commit(51);
    tick(); tick();
    @(negedge clk);
    chk(nlog == base + 2 && log_sc[base+1] == 2, "R7 uncacheable", log_sc[base+1], 2);
    resp(log_idx[base+1]);
    lock_flag = 0;
    push(32'h520, 52, 4, 52, 1, 0);
    commit(52);
    tick(); tick();
    @(negedge clk);
    chk(nlog == base + 2, "R7 lost lock no request", nlog - base, 2);
    chk(used_count == 0 && pending_count == 0, "R7 local finish", used_count, 0);

    // R2 full queue
    base = nlog;
    req_ready = 0;
    for (int s = 60; s < 64; s++) push(s * 16, s, 4, s, 0, 0);
    @(negedge clk);
    chk(alloc_ready == 0, "R2 full flag", alloc_ready, 0);
    chk(used_count == CAP, "R2 count", used_count, CAP);
    push(32'h640, 64, 4, 64, 0, 0);
    @(negedge clk);
    chk(used_count == CAP, "R2 full ignored", used_count, CAP);
    req_ready = 1;
    commit(64);
    repeat (6) tick();
    @(negedge clk);
    chk(nlog == base + 4, "R2 drained four", nlog - base, 4);
    chk(log_addr[base] == 60 * 16 && log_addr[base+3] == 63 * 16, "R4 wrap order", log_addr[base+3], 63 * 16);
    resp(log_idx[base+3]);
    resp(log_idx[base+2]);
    resp(log_idx[base+1]);
    @(negedge clk);
    chk(used_count == CAP, "R8 oldest pending", used_count, CAP);
    resp(log_idx[base]);
    @(negedge clk);
    chk(used_count == 0, "R8 full run retires", used_count, 0);
    chk(pending_count == 0, "R10 pending", pending_count, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule